// File: doc/BRIEF.md
# Shared-Aware Fully Associative TLB

A small fully associative translation lookaside buffer. Every entry carries a virtual page number, an address-space identifier, a physical page number and three flags: shared, dirty and valid. Three operations reach it. A lookup presents a page number together with the current address-space identifier and returns the matching entry. A load copies two page-table staging words into the entry chosen by a replacement pointer. An associative write finds the entry matching a page number and an identifier and rewrites that entry's dirty and valid flags.

The match rule is the heart of the block. An entry marked shared matches on its page number alone. When the processor is privileged and the single-virtual-space control is set, the identifier is ignored for every entry. Two or more matching entries raise a multiple-hit exception instead of a hit, and then nothing is modified. Clearing the valid flag of a live entry through an associative write raises a one-cycle flush request, so that copies of the translation held elsewhere can be dropped.

The replacement pointer moves only when a lookup misses. A load uses the pointer but does not move it, so repeated loads without an intervening miss overwrite the same entry.

Top module: `shared_tlb`

## Requirements
- R1: Reset (synchronous, active high) clears every valid flag and sets the replacement pointer to 0. In the cycle after reset, all result outputs are 0.
- R2: With `ld_req` high, the entry at the replacement pointer takes its page number from `pte_hi[VPN_W+ASID_W-1:ASID_W]` and its identifier from `pte_hi[ASID_W-1:0]`. From `pte_lo` it takes the physical page `[PPN_W+2:3]`, shared bit 2, dirty bit 1 and valid bit 0. The pointer does not change, and a load produces no hit, multi-hit or flush output.
- R3: A lookup that finds exactly one matching entry gives, one cycle later, `hit`=1, `hit_idx` set to the entry index, and `ppn_out` and `dirty_out` set to that entry's fields. Otherwise `hit`, `hit_idx`, `ppn_out` and `dirty_out` are 0.
- R4: An entry matches only when it is valid, its page number equals the key, and its identifier equals the key identifier, or its shared bit is set, or identifier checking is off.
- R5: Identifier checking is off exactly when `sv_mode`=1 and `priv`=1.
- R6: A lookup with no match advances the replacement pointer by one, wrapping from ENTRIES-1 to 0. Every other operation leaves the pointer unchanged.
- R7: When a lookup or associative write finds two or more matches, one cycle later `multi_hit`=1, `hit`=0 and `exc_code`=12'h140, and no entry changes. In every other cycle `exc_code` is 0.
- R8: An associative write uses `aw_data` bit 9 as the new dirty flag, bit 8 as the new valid flag, and bits 7:0 as the key identifier. It applies the R4 rule and updates only the single matching entry. One cycle later it reports `hit` and `hit_idx` as a lookup does, with `ppn_out`=0 and `dirty_out`=0.
- R9: `flush_req` pulses for one cycle, one cycle after an associative write whose single match was valid and whose new valid flag is 0.
- R10: When several requests arrive in one cycle, load wins over associative write, and associative write wins over lookup. The losing requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sv_mode | input | 1 | Single-virtual-space control |
| priv | input | 1 | Processor is in privileged mode |
| cur_asid | input | ASID_W | Current address-space identifier used by lookups |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup page number |
| ld_req | input | 1 | Load-entry request |
| pte_hi | input | VPN_W+ASID_W | Staging word: page number and identifier |
| pte_lo | input | PPN_W+3 | Staging word: physical page, shared, dirty, valid |
| aw_req | input | 1 | Associative write request |
| aw_vpn | input | VPN_W | Associative write page number |
| aw_data | input | ASID_W+2 | Dirty, valid and identifier for the associative write |
| hit | output | 1 | Single match found |
| hit_idx | output | $clog2(ENTRIES) | Index of the matching entry |
| ppn_out | output | PPN_W | Physical page of the lookup hit |
| dirty_out | output | 1 | Dirty flag of the lookup hit |
| multi_hit | output | 1 | Two or more entries matched |
| exc_code | output | 12 | Exception code, 12'h140 on multiple hit |
| flush_req | output | 1 | A valid translation was invalidated |

## Verification
Every result output is registered and is due exactly one clock edge after the edge that accepted the request. It then drops back to 0 in the following cycle unless another request arrives. The bench drives each request at a falling edge and compares all outputs at the next falling edge, which is half a period after the edge that captured them. A load has no result of its own. Its effects, and the movement of the replacement pointer, are checked through the index and page number returned by later lookups.

// File: rtl/shared_tlb_pkg.sv
package shared_tlb_pkg;
  localparam logic [11:0] MULTI_HIT_CODE = 12'h140;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_LOOK = 2'd1,
    OP_LOAD = 2'd2,
    OP_AWR  = 2'd3
  } tlb_op_e;
endpackage

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 8,
  parameter int ASID_W  = 8,
  parameter int PPN_W   = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic [VPN_W-1:0]               wr_vpn,
  input  logic [ASID_W-1:0]              wr_asid,
  input  logic [PPN_W-1:0]               wr_ppn,
  input  logic                           wr_sh,
  input  logic                           wr_d,
  input  logic                           wr_v,
  input  logic                           upd_en,
  input  logic [IDX_W-1:0]               upd_idx,
  input  logic                           upd_d,
  input  logic                           upd_v,
  output logic [ENTRIES-1:0][VPN_W-1:0]  vpn_o,
  output logic [ENTRIES-1:0][ASID_W-1:0] asid_o,
  output logic [ENTRIES-1:0][PPN_W-1:0]  ppn_o,
  output logic [ENTRIES-1:0]             sh_o,
  output logic [ENTRIES-1:0]             d_o,
  output logic [ENTRIES-1:0]             v_o
);
  // One register set per entry; every entry is compared in parallel.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic [VPN_W-1:0]  vpn_r;
    logic [ASID_W-1:0] asid_r;
    logic [PPN_W-1:0]  ppn_r;
    logic              sh_r, d_r, v_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        vpn_r  <= '0;
        asid_r <= '0;
        ppn_r  <= '0;
        sh_r   <= 1'b0;
        d_r    <= 1'b0;
        v_r    <= 1'b0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        vpn_r  <= wr_vpn;
        asid_r <= wr_asid;
        ppn_r  <= wr_ppn;
        sh_r   <= wr_sh;
        d_r    <= wr_d;
        v_r    <= wr_v;
      end else if (upd_en && upd_idx == IDX_W'(g)) begin
        d_r    <= upd_d;
        v_r    <= upd_v;
      end
    end

    assign vpn_o[g]  = vpn_r;
    assign asid_o[g] = asid_r;
    assign ppn_o[g]  = ppn_r;
    assign sh_o[g]   = sh_r;
    assign d_o[g]    = d_r;
    assign v_o[g]    = v_r;
  end
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 8,
  parameter int ASID_W  = 8
) (
  input  logic [VPN_W-1:0]               key_vpn,
  input  logic [ASID_W-1:0]              key_asid,
  input  logic                           use_asid,
  input  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_i,
  input  logic [ENTRIES-1:0][ASID_W-1:0] asid_i,
  input  logic [ENTRIES-1:0]             sh_i,
  input  logic [ENTRIES-1:0]             v_i,
  output logic [ENTRIES-1:0]             match_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic page_eq, id_ok;
    assign page_eq    = (vpn_i[g] == key_vpn);
    assign id_ok      = !use_asid || sh_i[g] || (asid_i[g] == key_asid);
    assign match_o[g] = v_i[g] && page_eq && id_ok;
  end
endmodule

// File: rtl/tlb_repl_ctr.sv
module tlb_repl_ctr #(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [IDX_W-1:0] cnt
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (adv)      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  a_r6_wraps_to_zero: assert property (@(posedge clk) disable iff (rst)
    (adv && cnt == LAST) |=> cnt == '0);
  a_r6_holds_without_miss: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(cnt));
endmodule

// File: rtl/shared_tlb.sv
module shared_tlb #(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 8,
  parameter int ASID_W  = 8,
  parameter int PPN_W   = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int HI_W   = VPN_W + ASID_W,
  localparam int LO_W   = PPN_W + 3,
  localparam int AWD_W  = ASID_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sv_mode,
  input  logic              priv,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              lk_req,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic              ld_req,
  input  logic [HI_W-1:0]   pte_hi,
  input  logic [LO_W-1:0]   pte_lo,
  input  logic              aw_req,
  input  logic [VPN_W-1:0]  aw_vpn,
  input  logic [AWD_W-1:0]  aw_data,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx,
  output logic [PPN_W-1:0]  ppn_out,
  output logic              dirty_out,
  output logic              multi_hit,
  output logic [11:0]       exc_code,
  output logic              flush_req
);
  import shared_tlb_pkg::*;

  tlb_op_e op;
  always_comb begin
    if (ld_req)      op = OP_LOAD;
    else if (aw_req) op = OP_AWR;
    else if (lk_req) op = OP_LOOK;
    else             op = OP_IDLE;
  end

  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_a;
  logic [ENTRIES-1:0][ASID_W-1:0] asid_a;
  logic [ENTRIES-1:0][PPN_W-1:0]  ppn_a;
  logic [ENTRIES-1:0]             sh_a, d_a, v_a, match;
  logic [IDX_W-1:0]               rep_idx, enc;
  logic [VPN_W-1:0]               key_vpn;
  logic [ASID_W-1:0]              key_asid;
  logic                           use_asid, any_m, many_m, one_m, searching;

  assign use_asid  = !(sv_mode && priv);
  assign key_vpn   = (op == OP_AWR) ? aw_vpn : lk_vpn;
  assign key_asid  = (op == OP_AWR) ? aw_data[ASID_W-1:0] : cur_asid;
  assign searching = (op == OP_LOOK) || (op == OP_AWR);

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) match_i (
    .key_vpn(key_vpn), .key_asid(key_asid), .use_asid(use_asid),
    .vpn_i(vpn_a), .asid_i(asid_a), .sh_i(sh_a), .v_i(v_a), .match_o(match)
  );

  assign any_m  = |match;
  assign many_m = |(match & (match - ENTRIES'(1)));
  assign one_m  = any_m && !many_m;

  always_comb begin
    enc = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) enc = IDX_W'(i);
  end

  tlb_repl_ctr #(.ENTRIES(ENTRIES)) ctr_i (
    .clk(clk), .rst(rst), .adv(op == OP_LOOK && !any_m), .cnt(rep_idx)
  );

  tlb_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PPN_W(PPN_W)) store_i (
    .clk(clk), .rst(rst),
    .wr_en(op == OP_LOAD), .wr_idx(rep_idx),
    .wr_vpn(pte_hi[HI_W-1:ASID_W]), .wr_asid(pte_hi[ASID_W-1:0]),
    .wr_ppn(pte_lo[LO_W-1:3]), .wr_sh(pte_lo[2]), .wr_d(pte_lo[1]), .wr_v(pte_lo[0]),
    .upd_en(op == OP_AWR && one_m), .upd_idx(enc),
    .upd_d(aw_data[ASID_W+1]), .upd_v(aw_data[ASID_W]),
    .vpn_o(vpn_a), .asid_o(asid_a), .ppn_o(ppn_a), .sh_o(sh_a), .d_o(d_a), .v_o(v_a)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit       <= 1'b0;
      hit_idx   <= '0;
      ppn_out   <= '0;
      dirty_out <= 1'b0;
      multi_hit <= 1'b0;
      exc_code  <= '0;
      flush_req <= 1'b0;
    end else begin
      hit       <= searching && one_m;
      hit_idx   <= (searching && one_m) ? enc : '0;
      ppn_out   <= (op == OP_LOOK && one_m) ? ppn_a[enc] : '0;
      dirty_out <= (op == OP_LOOK && one_m) ? d_a[enc] : 1'b0;
      multi_hit <= searching && many_m;
      exc_code  <= (searching && many_m) ? MULTI_HIT_CODE : 12'h000;
      flush_req <= (op == OP_AWR) && one_m && v_a[enc] && !aw_data[ASID_W];
    end
  end

  // Assertions (requirement tags in labels)
  a_r7_hit_multi_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(hit && multi_hit));
  a_r7_code_on_multi: assert property (@(posedge clk) disable iff (rst)
    multi_hit |-> exc_code == MULTI_HIT_CODE);
  a_r7_code_quiet: assert property (@(posedge clk) disable iff (rst)
    !multi_hit |-> exc_code == 12'h000);
  a_r2_load_keeps_ptr: assert property (@(posedge clk) disable iff (rst)
    ld_req |=> $stable(rep_idx));
  a_r10_load_silent: assert property (@(posedge clk) disable iff (rst)
    ld_req |=> (!hit && !multi_hit && !flush_req));
  a_r9_flush_after_awr: assert property (@(posedge clk) disable iff (rst)
    flush_req |-> (hit && $past(aw_req) && !$past(ld_req)));
  a_r7_multi_freezes_entries: assert property (@(posedge clk) disable iff (rst)
    (searching && many_m) |=> ($stable(v_a) && $stable(d_a)));

  for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
    a_r4_invalid_never_matches: assert property (@(posedge clk) disable iff (rst)
      !v_a[g] |-> !match[g]);
  end
endmodule

// File: tb/shared_tlb_tb_top.sv
`timescale 1ns/1ps
module shared_tlb_tb_top;
  logic clk = 1'b0;
  logic rst;
  always #2.5 clk = ~clk;

  logic        sv_mode, priv, lk_req, ld_req, aw_req;
  logic [7:0]  cur_asid, lk_vpn, aw_vpn;
  logic [15:0] pte_hi;
  logic [10:0] pte_lo;
  logic [9:0]  aw_data;
  logic        hit, dirty_out, multi_hit, flush_req;
  logic [1:0]  hit_idx;
  logic [7:0]  ppn_out;
  logic [11:0] exc_code;

  shared_tlb dut_i (
    .clk(clk), .rst(rst), .sv_mode(sv_mode), .priv(priv), .cur_asid(cur_asid),
    .lk_req(lk_req), .lk_vpn(lk_vpn), .ld_req(ld_req), .pte_hi(pte_hi),
    .pte_lo(pte_lo), .aw_req(aw_req), .aw_vpn(aw_vpn), .aw_data(aw_data),
    .hit(hit), .hit_idx(hit_idx), .ppn_out(ppn_out), .dirty_out(dirty_out),
    .multi_hit(multi_hit), .exc_code(exc_code), .flush_req(flush_req)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // op: 0 lookup, 1 load, 2 associative write
  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  vpn;
    logic [7:0]  asid;
    logic [10:0] lo;
    logic        sv;
    logic        pr;
    logic        e_hit;
    logic [1:0]  e_idx;
    logic [7:0]  e_ppn;
    logic        e_dirty;
    logic        e_multi;
    logic        e_flush;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 8'h10, 8'h01, 11'h000,          1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0},
    '{2'd1, 8'h10, 8'h01, {8'hA0, 3'b001},  1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0},
    '{2'd0, 8'h10, 8'h01, 11'h000,          1'b0, 1'b0, 1'b1, 2'd1, 8'hA0, 1'b0, 1'b0, 1'b0},
    '{2'd0, 8'h10, 8'h02, 11'h000,          1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0},
    '{2'd1, 8'h20, 8'h02, {8'hB0, 3'b101},  1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0},
    '{2'd0, 8'h20, 8'h09, 11'h000,          1'b0, 1'b0, 1'b1, 2'd2, 8'hB0, 1'b0, 1'b0, 1'b0},
    '{2'd1, 8'h30, 8'h03, {8'hC0, 3'b011},  1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0},
    '{2'd0, 8'h20, 8'h02, 11'h000,          1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0},
    '{2'd0, 8'h30, 8'h03, 11'h000,          1'b0, 1'b0, 1'b1, 2'd2, 8'hC0, 1'b1, 1'b0, 1'b0},
    '{2'd0, 8'h30, 8'h05, 11'h000,          1'b1, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0},
    '{2'd0, 8'h30, 8'h05, 11'h000,          1'b1, 1'b1, 1'b1, 2'd2, 8'hC0, 1'b1, 1'b0, 1'b0},
    '{2'd0, 8'h30, 8'h05, 11'h000,          1'b0, 1'b1, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0},
    '{2'd1, 8'h30, 8'h04, {8'hD0, 3'b001},  1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0},
    '{2'd0, 8'h30, 8'h04, 11'h000,          1'b0, 1'b0, 1'b1, 2'd1, 8'hD0, 1'b0, 1'b0, 1'b0},
    '{2'd0, 8'h30, 8'h09, 11'h000,          1'b1, 1'b1, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b0},
    '{2'd2, 8'h30, 8'h00, 11'h304,          1'b0, 1'b0, 1'b1, 2'd1, 8'h00, 1'b0, 1'b0, 1'b0},
    '{2'd0, 8'h30, 8'h04, 11'h000,          1'b0, 1'b0, 1'b1, 2'd1, 8'hD0, 1'b1, 1'b0, 1'b0},
    '{2'd2, 8'h30, 8'h00, 11'h0FF,          1'b1, 1'b1, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b0},
    '{2'd0, 8'h30, 8'h03, 11'h000,          1'b0, 1'b0, 1'b1, 2'd2, 8'hC0, 1'b1, 1'b0, 1'b0},
    '{2'd2, 8'h30, 8'h00, 11'h003,          1'b0, 1'b0, 1'b1, 2'd2, 8'h00, 1'b0, 1'b0, 1'b1},
    '{2'd0, 8'h30, 8'h03, 11'h000,          1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0},
    '{2'd2, 8'h30, 8'h00, 11'h203,          1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0},
    '{2'd1, 8'h40, 8'h06, {8'hE0, 3'b001},  1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0},
    '{2'd0, 8'h40, 8'h06, 11'h000,          1'b0, 1'b0, 1'b1, 2'd2, 8'hE0, 1'b0, 1'b0, 1'b0}
  };

  function automatic string req_of(vec_t v);
    if (v.op == 2'd1)  return "R2";
    if (v.e_multi)     return "R7";
    if (v.e_flush)     return "R9";
    if (v.op == 2'd2)  return "R8";
    if (v.sv)          return "R5";
    if (!v.e_hit)      return "R4/R6";
    return "R3";
  endfunction

  task automatic idle_inputs();
    lk_req = 0; ld_req = 0; aw_req = 0;
  endtask

  task automatic check(string tag, logic e_hit, logic [1:0] e_idx, logic [7:0] e_ppn,
                       logic e_dirty, logic e_multi, logic e_flush);
    logic [23:0] act, exp;
    act = {hit, hit_idx, ppn_out, dirty_out, multi_hit, flush_req, exc_code[11:2]};
    exp = {e_hit, e_idx, e_ppn, e_dirty, e_multi, e_flush, e_multi ? 10'h050 : 10'h000};
    total++;
    if (act !== exp || exc_code[1:0] !== 2'b00) begin
      bad++;
      $display("FAIL %s actual=%h/%h expected=%h/%h", tag, act, exc_code, exp,
               e_multi ? 12'h140 : 12'h000);
    end
  endtask

  // Drive one request at a falling edge; the result is due at the next falling edge.
  task automatic apply(vec_t v);
    @(negedge clk);
    sv_mode = v.sv; priv = v.pr;
    case (v.op)
      2'd0: begin lk_req = 1; lk_vpn = v.vpn; cur_asid = v.asid; end
      2'd1: begin ld_req = 1; pte_hi = {v.vpn, v.asid}; pte_lo = v.lo; end
      default: begin aw_req = 1; aw_vpn = v.vpn; aw_data = v.lo[9:0]; end
    endcase
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; idle_inputs();
    @(negedge clk);
    @(negedge clk);
    rst = 0;
  endtask

  initial begin
    rst = 1; sv_mode = 0; priv = 0; cur_asid = 0; lk_vpn = 0; aw_vpn = 0;
    pte_hi = 0; pte_lo = 0; aw_data = 0; idle_inputs();
    do_reset();
    @(negedge clk);
    check("R1 reset state", 0, 2'd0, 8'h00, 0, 0, 0);

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i]);
      check($sformatf("%s row %0d", req_of(TBL[i]), i), TBL[i].e_hit, TBL[i].e_idx,
            TBL[i].e_ppn, TBL[i].e_dirty, TBL[i].e_multi, TBL[i].e_flush);
    end

    // R10: load and lookup together; the load wins (pointer is 2) and the lookup is dropped.
    @(negedge clk);
    sv_mode = 0; priv = 0;
    ld_req = 1; pte_hi = {8'h50, 8'h07}; pte_lo = {8'hF0, 3'b001};
    lk_req = 1; lk_vpn = 8'h40; cur_asid = 8'h06;
    @(negedge clk);
    idle_inputs();
    check("R10 load beats lookup", 0, 2'd0, 8'h00, 0, 0, 0);
    apply('{2'd0, 8'h50, 8'h07, 11'h000, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0});
    check("R10 R2 loaded entry visible", 1, 2'd2, 8'hF0, 0, 0, 0);

    // R10: associative write beats lookup; the write clears entry 2 and flushes.
    @(negedge clk);
    aw_req = 1; aw_vpn = 8'h50; aw_data = 10'h007;
    lk_req = 1; lk_vpn = 8'h50; cur_asid = 8'h07;
    @(negedge clk);
    idle_inputs();
    check("R10 R9 write beats lookup", 1, 2'd2, 8'h00, 0, 0, 1);
    @(negedge clk);
    check("R9 flush is one cycle", 0, 2'd0, 8'h00, 0, 0, 0);

    // R1 mid-run reset: old entry gone, pointer back at 0 then moved to 1 by a miss (R6).
    do_reset();
    @(negedge clk);
    check("R1 outputs after reset", 0, 2'd0, 8'h00, 0, 0, 0);
    apply('{2'd0, 8'h30, 8'h04, 11'h000, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0});
    check("R1 entries invalid after reset", 0, 2'd0, 8'h00, 0, 0, 0);
    apply('{2'd1, 8'h60, 8'h01, {8'h11, 3'b001}, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0});
    apply('{2'd0, 8'h60, 8'h01, 11'h000, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0});
    check("R1 R6 pointer restarted at 0", 1, 2'd1, 8'h11, 0, 0, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1..R10 actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule